// File: doc/BRIEF.md
# Many-Time-Programmable Flash Mode Controller

This block is the control core of a byte-wide flash memory that is reprogrammed by an external programmer and has no command protocol. The mode comes straight from the levels on the control pins. These are chip enable, output enable and write enable, plus two flags that report a high-voltage level on the output-enable pin and on the A9 address pin. The block decodes six modes from them: standby, read, output-off, identification, byte program and chip erase. It then applies the selected mode to a small on-chip byte array.

The data bus is split into an output byte, an output-enable flag and an input byte. A write-enable falling edge is detected synchronously in the system clock. In program or erase mode, that edge latches the operation, the address and the data, and starts a timed operation that lasts a parameterised number of cycles. The array changes on the cycle the busy flag drops.

Programming can only clear bits, because the stored byte becomes the AND of the old byte and the input. Only a whole-array erase can return bits to 1.

Top module: `mtp_flash_ctrl`

## Requirements
- R1: With `ce_ni` high the block is in standby. `data_oe_o` is 0, and write-enable edges start nothing: `busy_o` stays 0 and the array is unchanged.
- R2: With `ce_ni`=0, `oe_ni`=0, `oe_hv_i`=0 and `a9_hv_i`=0 (read), `data_oe_o` is 1 and `data_o` equals the byte at `addr_i`.
- R3: With `ce_ni`=0, `oe_ni`=1 and `oe_hv_i`=0 (output-off), `data_oe_o` is 0.
- R4: With `ce_ni`=0, `oe_ni`=0, `oe_hv_i`=0 and `a9_hv_i`=1 (identification), `data_oe_o` is 1. Address 0 returns `MFR_ID` (default 0xBF) and address 1 returns `DEV_ID` (default 0xC5). Any address with a nonzero bit above bit 0 returns 0x00.
- R5: With `ce_ni`=0, `oe_hv_i`=1 and `a9_hv_i`=0 (program), a write-enable falling edge latches `addr_i` and `data_i`. When busy ends, that byte holds the old byte AND the latched data.
- R6: Programming never sets a bit. Writing 0xFF over a byte leaves the byte as it was.
- R7: With `ce_ni`=0, `oe_hv_i`=1 and `a9_hv_i`=1 (erase), a write-enable falling edge starts an erase. When busy ends, every byte is 0xFF whatever `addr_i` and `data_i` were.
- R8: `busy_o` rises on the clock edge that first samples `we_ni` low after a high sample. It stays high for exactly `PROG_CYCLES` cycles (program, default 4) or `ERASE_CYCLES` cycles (erase, default 16). Falling edges that arrive while it is high are ignored.
- R9: After reset `busy_o` is 0 and every byte reads 0xFF.
- R10: Only a falling edge starts an operation. Holding `we_ni` low does not restart it, and a falling edge in read, output-off or identification mode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low (normal logic level) |
| we_ni | input | 1 | Write enable, active low |
| oe_hv_i | input | 1 | High voltage present on output-enable pin |
| a9_hv_i | input | 1 | High voltage present on A9 pin |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Data bus input side |
| data_o | output | DATA_W | Data bus output side |
| data_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The bench programs every address twice with different patterns and then writes all-ones. A design that stored the input instead of ANDing it would fail the second pass and the all-ones pass. The bench also sends a second write-enable pulse to another address while the first operation is still busy, and it holds write enable low across the end of a program. A design that restarted on a level, or that accepted edges while busy, would then corrupt the second address or stretch busy. The bench sweeps the identification address space, so a decode that ignored the upper address bits would return codes at aliased addresses. It also erases with junk address and data, so an erase that honoured those inputs would leave bytes other than 0xFF.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_OUT_OFF,
    MODE_ID,
    MODE_PROG,
    MODE_ERASE
  } mode_e;

  typedef enum logic {
    OP_PROG,
    OP_ERASE
  } op_e;
endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
  import mtp_pkg::*;
(
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  oe_hv_i,
  input  logic  a9_hv_i,
  output mode_e mode_o
);
  always_comb begin
    if (ce_ni)                   mode_o = MODE_STANDBY;
    else if (oe_hv_i && a9_hv_i) mode_o = MODE_ERASE;
    else if (oe_hv_i)            mode_o = MODE_PROG;
    else if (oe_ni)              mode_o = MODE_OUT_OFF;
    else if (a9_hv_i)            mode_o = MODE_ID;
    else                         mode_o = MODE_READ;
  end
endmodule

// File: rtl/mtp_op_seq.sv
module mtp_op_seq
  import mtp_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_ni,
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_fall_o,
  output logic              busy_o,
  output logic              commit_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);

  logic             we_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;

  assign we_fall_o = we_q & ~we_ni;
  assign start     = we_fall_o & ~busy_q & (mode_i == MODE_PROG || mode_i == MODE_ERASE);
  assign commit_o  = busy_q & (cnt_q == '0);
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_o   <= OP_PROG;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_q <= we_ni;
      if (start) begin
        busy_q <= 1'b1;
        addr_o <= addr_i;
        data_o <= data_i;
        if (mode_i == MODE_ERASE) begin
          op_o  <= OP_ERASE;
          cnt_q <= ERASE_LAST;
        end else begin
          op_o  <= OP_PROG;
          cnt_q <= PROG_LAST;
        end
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtp_byte_array.sv
module mtp_byte_array
  import mtp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '1;
      end else if (commit_i) begin
        if (op_i == OP_ERASE)
          mem_q[g] <= '1;
        else if (waddr_i == ADDR_W'(g))
          mem_q[g] <= mem_q[g] & wdata_i;  // program clears bits only
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mtp_flash_ctrl.sv
module mtp_flash_ctrl
  import mtp_pkg::*;
#(
  parameter int                ADDR_W       = 4,
  parameter int                DATA_W       = 8,
  parameter int                PROG_CYCLES  = 4,
  parameter int                ERASE_CYCLES = 16,
  parameter logic [DATA_W-1:0] MFR_ID       = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_ID       = 8'hC5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              oe_hv_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  mode_e             mode;
  logic              we_fall;
  logic              commit;
  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] id_byte;

  mtp_mode_decode u_decode (
    .ce_ni   (ce_ni),
    .oe_ni   (oe_ni),
    .oe_hv_i (oe_hv_i),
    .a9_hv_i (a9_hv_i),
    .mode_o  (mode)
  );

  mtp_op_seq #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_ni     (we_ni),
    .mode_i    (mode),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .we_fall_o (we_fall),
    .busy_o    (busy_o),
    .commit_o  (commit),
    .op_o      (op),
    .addr_o    (op_addr),
    .data_o    (op_data)
  );

  mtp_byte_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .op_i     (op),
    .waddr_i  (op_addr),
    .wdata_i  (op_data),
    .raddr_i  (addr_i),
    .rdata_o  (rdata)
  );

  // identification codes only at the two lowest addresses
  always_comb begin
    if (addr_i[ADDR_W-1:1] != '0) id_byte = '0;
    else if (addr_i[0])           id_byte = DEV_ID;
    else                          id_byte = MFR_ID;
  end

  assign data_oe_o = (mode == MODE_READ) || (mode == MODE_ID);
  assign data_o    = (mode == MODE_READ) ? rdata :
                     (mode == MODE_ID)   ? id_byte : '0;
endmodule

// File: rtl/mtp_flash_ctrl_chk.sv
module mtp_flash_ctrl_chk
  import mtp_pkg::*;
#(
  parameter int                ADDR_W       = 4,
  parameter int                DATA_W       = 8,
  parameter int                PROG_CYCLES  = 4,
  parameter int                ERASE_CYCLES = 16,
  parameter logic [DATA_W-1:0] MFR_ID       = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_ID       = 8'hC5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              oe_hv_i,
  input logic              a9_hv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              busy_o,
  input logic              we_fall,
  input mode_e             mode
);
  int unsigned len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= 0;
    else if (busy_o) len_q <= len_q + 1;
    else             len_q <= 0;
  end

  a_r1_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o);

  a_r1_standby_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !busy_o) |=> !busy_o);

  a_r2_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !oe_hv_i && !a9_hv_i) |-> data_oe_o);

  a_r3_out_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && oe_ni && !oe_hv_i) |-> !data_oe_o);

  a_r4_mfr_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !oe_hv_i && a9_hv_i && addr_i == '0)
      |-> (data_oe_o && data_o == MFR_ID));

  a_r4_dev_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni && !oe_hv_i && a9_hv_i && addr_i == ADDR_W'(1))
      |-> (data_oe_o && data_o == DEV_ID));

  a_r8_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(we_fall) &&
                       ($past(mode) == MODE_PROG || $past(mode) == MODE_ERASE)));

  a_r8_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len_q == PROG_CYCLES || len_q == ERASE_CYCLES));
endmodule

bind mtp_flash_ctrl mtp_flash_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .PROG_CYCLES  (PROG_CYCLES),
  .ERASE_CYCLES (ERASE_CYCLES),
  .MFR_ID       (MFR_ID),
  .DEV_ID       (DEV_ID)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .oe_hv_i   (oe_hv_i),
  .a9_hv_i   (a9_hv_i),
  .addr_i    (addr_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .busy_o    (busy_o),
  .we_fall   (we_fall),
  .mode      (mode)
);

// File: tb/mtp_flash_ctrl_tb_top.sv
`timescale 1ns/1ps
module mtp_flash_ctrl_tb_top;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int PCYC  = 4;
  localparam int ECYC  = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          doe, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  mtp_flash_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC),
    .MFR_ID(8'hBF), .DEV_ID(8'hC5)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .oe_hv_i(oe_hv), .a9_hv_i(a9_hv), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic ce, input logic oe, input logic ohv, input logic ahv);
    ce_n = ce; oe_n = oe; oe_hv = ohv; a9_hv = ahv;
  endtask

  // one write-enable pulse, then count busy cycles until idle
  task automatic pulse(output int len);
    @(negedge clk) we_n = 1'b0;
    @(negedge clk) we_n = 1'b1;
    len = 0;
    while (busy && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic read_all(input string req);
    @(negedge clk) set_mode(0, 0, 0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a);
      #2;
      chk(req, {31'd0, doe}, 32'd1);
      chk(req, {24'd0, dout}, {24'd0, model[a]});
      @(negedge clk);
    end
  endtask

  task automatic program_pass(input int mul, input int add, input string req);
    int len;
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] d;
      d = DW'((a * mul + add) & 8'hFF);
      @(negedge clk) set_mode(0, 1, 1, 0);
      addr = AW'(a); din = d;
      pulse(len);
      chk("R8 prog busy length", len, PCYC);
      model[a] = model[a] & d;
    end
    read_all(req);
  endtask

  initial begin
    int len;
    logic [DW-1:0] before3, before4;
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    repeat (3) @(negedge clk);
    #2;
    chk("R9 busy after reset", {31'd0, busy}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R9 / R2: erased contents after reset
    read_all("R9 R2 reset contents");

    // R5: two passes, AND semantics
    program_pass(37, 5, "R5 program pass 1");
    program_pass(91, 200, "R5 program pass 2");

    // R6: all-ones leaves bytes unchanged
    program_pass(0, 255, "R6 all-ones program");

    // R3: output-off sweep
    @(negedge clk) set_mode(0, 1, 0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a); #2;
      chk("R3 output off", {31'd0, doe}, 32'd0);
      @(negedge clk);
    end
    a9_hv = 1'b1; #2;
    chk("R3 output off with a9 hv", {31'd0, doe}, 32'd0);

    // R4: identification sweep
    @(negedge clk) set_mode(0, 0, 0, 1);
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a); #2;
      chk("R4 id drive", {31'd0, doe}, 32'd1);
      chk("R4 id code", {24'd0, dout}, (a == 0) ? 32'hBF : (a == 1) ? 32'hC5 : 32'h00);
      @(negedge clk);
    end

    // R1: standby ignores pulses in every hv combination
    for (int m = 0; m < 4; m++) begin
      @(negedge clk) set_mode(1, 0, m[0], m[1]);
      addr = AW'(m); din = '0; #2;
      chk("R1 standby no drive", {31'd0, doe}, 32'd0);
      pulse(len);
      chk("R1 standby no busy", len, 0);
    end
    read_all("R1 standby array unchanged");

    // R10: pulses in read, output-off and id modes do nothing
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      if (m == 0) set_mode(0, 0, 0, 0);
      else if (m == 1) set_mode(0, 1, 0, 0);
      else set_mode(0, 0, 0, 1);
      addr = AW'(2); din = '0;
      pulse(len);
      chk("R10 non-write mode no busy", len, 0);
    end
    read_all("R10 non-write mode array unchanged");

    // R10: held-low write enable runs one operation only
    @(negedge clk) set_mode(0, 1, 1, 0);
    addr = AW'(5); din = 8'h00;
    we_n = 1'b0;
    len = 0;
    for (int c = 0; c < PCYC + 6; c++) begin
      @(negedge clk);
      if (busy) len++;
    end
    chk("R10 held low single op", len, PCYC);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 rising edge no start", {31'd0, busy}, 32'd0);
    model[5] = 8'h00;

    // R8: second pulse during busy is ignored
    before3 = model[3]; before4 = model[4];
    @(negedge clk) set_mode(0, 1, 1, 0);
    addr = AW'(3); din = 8'h0F;
    we_n = 1'b0;
    @(negedge clk) we_n = 1'b1;
    addr = AW'(4); din = 8'h00;
    @(negedge clk) we_n = 1'b0;
    @(negedge clk) we_n = 1'b1;
    len = 2;
    while (busy && len < 100) begin len++; @(negedge clk); end
    chk("R8 busy not extended", len, PCYC);
    repeat (2) @(negedge clk);
    chk("R8 ignored pulse no busy", {31'd0, busy}, 32'd0);
    model[3] = before3 & 8'h0F;
    model[4] = before4;
    read_all("R8 ignored pulse array");

    // R7: erase with junk address and data
    @(negedge clk) set_mode(0, 0, 1, 1);
    addr = AW'(9); din = 8'h00; #2;
    chk("R7 erase mode no drive", {31'd0, doe}, 32'd0);
    pulse(len);
    chk("R7 R8 erase busy length", len, ECYC);
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    read_all("R7 erased to ones");

    // R5: program after erase
    program_pass(13, 7, "R5 program after erase");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule